// File: doc/BRIEF.md
# Write-Protection Command Sequencer

This block sits on the qualified write stream of a page-programmed non-volatile memory. It looks for two fixed command sequences of address and data writes. One sequence arms write protection and the other releases it. For every write it makes one of three decisions: the write is a command step, the write is a data load the array may commit, or the write is an illegal write that is discarded. It keeps a protect flag that survives an ordinary reset. Only a separate power-on initialisation input clears that flag.

The memory timing logic supplies three things: a one-cycle pulse for each accepted write, the write's word address and data, and a pulse when the page-load window closes. The array commits a word only when this block raises its commit pulse. While protection is armed, each load burst must begin with the three-step unlock prefix. A data word is several byte lanes wide. A command byte counts only when it appears in every lane.

Top module: `sdp_sequencer`

## Requirements
- R1: The three writes 0xAA to word address 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555 arm protection. `protectOn` reads 1 the cycle after the next `windowEnd` pulse, even if no data load followed.
- R2: The six writes 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555 release protection. Data loads that follow in the same window commit. `protectOn` reads 0 the cycle after the next `windowEnd`.
- R3: Every write that matches the expected next command step gives `cmdCycle`=1 and `commitOk`=0. A command write never commits to the array.
- R4: While unprotected, a write that is not part of a command sequence gives `commitOk`=1 and `cmdCycle`=0.
- R5: While protected, a write that is not preceded in its window by the unlock prefix is discarded. It gives `commitOk`=0 and `cmdCycle`=0.
- R6: After the three-step prefix (ending 0xA0@0x5555), every further write in the same window is a data load with `commitOk`=1. Protection is still armed (or re-armed) at the window end.
- R7: A write that does not match the expected next step aborts the sequence. It is then handled as a non-command write under R4 or R5. The exception is 0xAA@0x5555: that write restarts the sequence as its first step.
- R8: A data byte matches a command byte only if every byte lane holds it (lane k is `wrData[8k+7:8k]`). The address must match in all `ADDR_W` bits.
- R9: A `windowEnd` that arrives while a sequence is incomplete abandons that sequence. `protectOn` does not change.
- R10: `rstN` low clears the sequence and the output pulses but leaves `protectOn` unchanged. `porInit` high clears `protectOn` on the next clock.
- R11: `commitOk` and `cmdCycle` are one-cycle pulses registered in the cycle after the `wrValid` pulse. `protectOn` changes only in the cycle after a `windowEnd` pulse or a `porInit` request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset of sequence and pulses |
| porInit | input | 1 | Power-on initialisation; clears the protect flag |
| wrValid | input | 1 | One-cycle pulse for each qualified write |
| wrAddr | input | ADDR_W | Word address of the write |
| wrData | input | 8*LANES | Write data, LANES byte lanes |
| windowEnd | input | 1 | Page-load window has closed |
| commitOk | output | 1 | The previous write may be committed to the array |
| cmdCycle | output | 1 | The previous write was a command step |
| protectOn | output | 1 | Write protection is armed |

## Verification
On every cycle the assertions check four things: the two write pulses are never high together, neither pulse appears without a write in the cycle before, the protect flag moves only after a window end or an initialisation request, and initialisation always leaves the flag clear. Some behaviour can only be shown by the bench's scenarios: whether a given sequence arms or releases protection, whether an abort at each step position is classified correctly in both protect states, and whether a single corrupted lane or a single flipped address bit defeats a match.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
  localparam logic [7:0] BYTE_LEAD    = 8'hAA;
  localparam logic [7:0] BYTE_SECOND  = 8'h55;
  localparam logic [7:0] BYTE_ARM     = 8'hA0;
  localparam logic [7:0] BYTE_EXTEND  = 8'h80;
  localparam logic [7:0] BYTE_RELEASE = 8'h20;

  typedef enum logic [2:0] {
    SEQ_IDLE, SEQ_LEAD, SEQ_SECOND, SEQ_OPEN,
    SEQ_EXT, SEQ_EXT_LEAD, SEQ_EXT_SECOND, SEQ_RELEASE
  } seq_t;

  // Decoded matches of the current write against the command steps.
  typedef struct packed {
    logic leadAtA;
    logic secondAtB;
    logic armAtA;
    logic extendAtA;
    logic releaseAtA;
  } hits_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic commit;
    logic cmd;
    logic setProt;
    logic clrProt;
  } strobe_t;
endpackage

// File: rtl/sdp_datapath.sv
module sdp_datapath
  import sdp_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int LANES = 2,
  parameter logic [ADDR_W-1:0] CMD_ADDR_A = ADDR_W'(15'h5555),
  parameter logic [ADDR_W-1:0] CMD_ADDR_B = ADDR_W'(15'h2AAA),
  localparam int DATA_W = LANES * 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              porInit,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  strobe_t           strobe,
  output hits_t             hits,
  output logic              commitOk,
  output logic              cmdCycle,
  output logic              protectOn
);
  logic [LANES-1:0] laneLead, laneSecond, laneArm, laneExtend, laneRelease;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [7:0] laneByte;
    assign laneByte       = wrData[8*k +: 8];
    assign laneLead[k]    = (laneByte == BYTE_LEAD);
    assign laneSecond[k]  = (laneByte == BYTE_SECOND);
    assign laneArm[k]     = (laneByte == BYTE_ARM);
    assign laneExtend[k]  = (laneByte == BYTE_EXTEND);
    assign laneRelease[k] = (laneByte == BYTE_RELEASE);
  end

  logic atA, atB;
  assign atA = (wrAddr == CMD_ADDR_A);
  assign atB = (wrAddr == CMD_ADDR_B);

  always_comb begin
    hits.leadAtA    = atA && (&laneLead);
    hits.secondAtB  = atB && (&laneSecond);
    hits.armAtA     = atA && (&laneArm);
    hits.extendAtA  = atA && (&laneExtend);
    hits.releaseAtA = atA && (&laneRelease);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      commitOk <= 1'b0;
      cmdCycle <= 1'b0;
    end else begin
      commitOk <= strobe.commit;
      cmdCycle <= strobe.cmd;
    end
  end

  // Persistent flag: only power-on init clears it, ordinary reset does not.
  always_ff @(posedge clk) begin
    if (porInit)              protectOn <= 1'b0;
    else if (strobe.setProt)  protectOn <= 1'b1;
    else if (strobe.clrProt)  protectOn <= 1'b0;
  end
endmodule

// File: rtl/sdp_ctrl.sv
module sdp_ctrl
  import sdp_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    wrValid,
  input  logic    windowEnd,
  input  hits_t   hits,
  input  logic    protectOn,
  output strobe_t strobe
);
  seq_t state, afterWr, stepNext;
  logic stepHit;

  always_comb begin
    stepHit  = 1'b0;
    stepNext = SEQ_IDLE;
    case (state)
      SEQ_IDLE:       begin stepHit = hits.leadAtA;    stepNext = SEQ_LEAD;       end
      SEQ_LEAD:       begin stepHit = hits.secondAtB;  stepNext = SEQ_SECOND;     end
      SEQ_SECOND: begin
        if (hits.armAtA)         begin stepHit = 1'b1; stepNext = SEQ_OPEN; end
        else if (hits.extendAtA) begin stepHit = 1'b1; stepNext = SEQ_EXT;  end
      end
      SEQ_EXT:        begin stepHit = hits.leadAtA;    stepNext = SEQ_EXT_LEAD;   end
      SEQ_EXT_LEAD:   begin stepHit = hits.secondAtB;  stepNext = SEQ_EXT_SECOND; end
      SEQ_EXT_SECOND: begin stepHit = hits.releaseAtA; stepNext = SEQ_RELEASE;    end
      default: ;
    endcase
  end

  always_comb begin
    strobe  = '0;
    afterWr = state;
    if (wrValid) begin
      if (state == SEQ_OPEN || state == SEQ_RELEASE) begin
        strobe.commit = 1'b1;
      end else if (stepHit) begin
        strobe.cmd = 1'b1;
        afterWr    = stepNext;
      end else if (hits.leadAtA) begin
        strobe.cmd = 1'b1;
        afterWr    = SEQ_LEAD;
      end else begin
        strobe.commit = !protectOn;
        afterWr       = SEQ_IDLE;
      end
    end
    strobe.setProt = windowEnd && (afterWr == SEQ_OPEN);
    strobe.clrProt = windowEnd && (afterWr == SEQ_RELEASE);
  end

  always_ff @(posedge clk) begin
    if (!rstN)          state <= SEQ_IDLE;
    else if (windowEnd) state <= SEQ_IDLE;
    else                state <= afterWr;
  end
endmodule

// File: rtl/sdp_sequencer.sv
module sdp_sequencer
  import sdp_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int LANES = 2,
  parameter logic [ADDR_W-1:0] CMD_ADDR_A = ADDR_W'(15'h5555),
  parameter logic [ADDR_W-1:0] CMD_ADDR_B = ADDR_W'(15'h2AAA),
  localparam int DATA_W = LANES * 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              porInit,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              windowEnd,
  output logic              commitOk,
  output logic              cmdCycle,
  output logic              protectOn
);
  hits_t   hits;
  strobe_t strobe;

  sdp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .windowEnd(windowEnd),
    .hits(hits), .protectOn(protectOn), .strobe(strobe)
  );

  sdp_datapath #(
    .ADDR_W(ADDR_W), .LANES(LANES),
    .CMD_ADDR_A(CMD_ADDR_A), .CMD_ADDR_B(CMD_ADDR_B)
  ) u_dp (
    .clk(clk), .rstN(rstN), .porInit(porInit), .wrAddr(wrAddr),
    .wrData(wrData), .strobe(strobe), .hits(hits),
    .commitOk(commitOk), .cmdCycle(cmdCycle), .protectOn(protectOn)
  );
endmodule

// File: rtl/sdp_guard.sv
module sdp_guard (
  input logic clk,
  input logic rstN,
  input logic porInit,
  input logic wrValid,
  input logic windowEnd,
  input logic commitOk,
  input logic cmdCycle,
  input logic protectOn
);
  assert_exclusive_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(commitOk && cmdCycle));

  assert_pulse_follows_write_R11: assert property (@(posedge clk) disable iff (!rstN)
    (commitOk || cmdCycle) |-> $past(wrValid));

  assert_flag_moves_on_window_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(protectOn) && !$past(porInit)) |-> $past(windowEnd));

  assert_init_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
    porInit |=> !protectOn);
endmodule

bind sdp_sequencer sdp_guard u_guard (.*);

// File: tb/sdp_sequencer_test.sv
module sdp_sequencer_test;
  localparam int AW = 15;
  localparam int LN = 2;
  localparam int DW = LN * 8;
  localparam logic [AW-1:0] A_ADDR = 15'h5555;
  localparam logic [AW-1:0] B_ADDR = 15'h2AAA;
  localparam logic [AW-1:0] PLAIN  = 15'h0123;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, porInit, wrValid, windowEnd;
  logic [AW-1:0] wrAddr;
  logic [DW-1:0] wrData;
  logic commitOk, cmdCycle, protectOn;

  sdp_sequencer #(.ADDR_W(AW), .LANES(LN)) uut (
    .clk(clk), .rstN(rstN), .porInit(porInit), .wrValid(wrValid),
    .wrAddr(wrAddr), .wrData(wrData), .windowEnd(windowEnd),
    .commitOk(commitOk), .cmdCycle(cmdCycle), .protectOn(protectOn)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rep(input logic [7:0] b);
    return {LN{b}};
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                    input logic expCommit, input logic expCmd, input string tag);
    @(negedge clk);
    wrAddr = a; wrData = d; wrValid = 1'b1;
    @(negedge clk);
    wrValid = 1'b0;
    chk({tag, " commitOk"}, commitOk, expCommit);
    chk({tag, " cmdCycle"}, cmdCycle, expCmd);
  endtask

  task automatic cmdw(input logic [AW-1:0] a, input logic [7:0] b);
    wr(a, rep(b), 1'b0, 1'b1, "R3 command step");
  endtask

  task automatic winEnd(input logic expProt, input string tag);
    @(negedge clk);
    windowEnd = 1'b1;
    @(negedge clk);
    windowEnd = 1'b0;
    chk({tag, " protectOn"}, protectOn, expProt);
  endtask

  task automatic disableStep(input int i);
    case (i)
      0: cmdw(A_ADDR, 8'hAA);
      1: cmdw(B_ADDR, 8'h55);
      2: cmdw(A_ADDR, 8'h80);
      3: cmdw(A_ADDR, 8'hAA);
      4: cmdw(B_ADDR, 8'h55);
      default: cmdw(A_ADDR, 8'h20);
    endcase
  endtask

  task automatic enablePrefix();
    cmdw(A_ADDR, 8'hAA);
    cmdw(B_ADDR, 8'h55);
    cmdw(A_ADDR, 8'hA0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; porInit = 1'b1; wrValid = 1'b0; windowEnd = 1'b0;
    wrAddr = '0; wrData = '0;
    repeat (3) @(negedge clk);
    porInit = 1'b0; rstN = 1'b1;
    @(negedge clk);
    chk("R10 reset protectOn", protectOn, 1'b0);
    chk("R11 reset commitOk", commitOk, 1'b0);
    chk("R11 reset cmdCycle", cmdCycle, 1'b0);

    // R4: plain writes while unprotected commit
    for (int i = 0; i < 4; i++)
      wr(AW'(i * 16'h1111), DW'(16'h1234 + i), 1'b1, 1'b0, "R4 plain write");

    // R11: pulse lasts one cycle
    @(negedge clk);
    chk("R11 pulse ends", commitOk, 1'b0);

    // R1: arm without data loads
    enablePrefix();
    winEnd(1'b1, "R1 armed");

    // R5: protected plain writes discarded
    for (int i = 0; i < 4; i++)
      wr(PLAIN + AW'(i), DW'(16'h4321), 1'b0, 1'b0, "R5 discarded");

    // R6: prefix then loads commit, protection stays
    enablePrefix();
    for (int i = 0; i < 3; i++)
      wr(PLAIN + AW'(i), rep(8'hAA), 1'b1, 1'b0, "R6 load");
    winEnd(1'b1, "R6 still armed");

    // R10: ordinary reset keeps the flag
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    chk("R10 flag survives reset", protectOn, 1'b1);

    // R7/R9: abort after each disable step while protected
    for (int n = 0; n < 6; n++) begin
      for (int s = 0; s < n; s++) disableStep(s);
      wr(PLAIN, DW'(16'h1234), 1'b0, 1'b0, "R7 abort protected");
      winEnd(1'b1, "R9 protect kept");
    end

    // R2: release with loads
    for (int s = 0; s < 6; s++) disableStep(s);
    wr(PLAIN, DW'(16'h0F0F), 1'b1, 1'b0, "R2 load after release");
    wr(PLAIN + 1, DW'(16'hF0F0), 1'b1, 1'b0, "R2 load after release");
    winEnd(1'b0, "R2 released");

    // R7/R9: abort after each step while unprotected
    for (int n = 0; n < 6; n++) begin
      for (int s = 0; s < n; s++) disableStep(s);
      wr(PLAIN, DW'(16'h1234), 1'b1, 1'b0, "R7 abort unprotected");
      winEnd(1'b0, "R9 unprotected kept");
    end

    // R7: lead step restarts a sequence
    cmdw(A_ADDR, 8'hAA);
    cmdw(B_ADDR, 8'h55);
    wr(A_ADDR, rep(8'hAA), 1'b0, 1'b1, "R7 restart");
    cmdw(B_ADDR, 8'h55);
    cmdw(A_ADDR, 8'hA0);
    winEnd(1'b1, "R7 armed after restart");
    for (int s = 0; s < 6; s++) disableStep(s);
    winEnd(1'b0, "R2 released again");

    // R9: window end abandons a partial prefix
    cmdw(A_ADDR, 8'hAA);
    cmdw(B_ADDR, 8'h55);
    winEnd(1'b0, "R9 partial abandoned");
    wr(A_ADDR, rep(8'hA0), 1'b1, 1'b0, "R9 late arm byte is data");
    winEnd(1'b0, "R9 not armed");

    // R8: each corrupted lane defeats a match
    for (int k = 0; k < LN; k++) begin
      logic [DW-1:0] d;
      d = rep(8'hAA);
      d[8*k +: 8] = 8'hAB;
      wr(A_ADDR, d, 1'b1, 1'b0, "R8 lane mismatch");
    end
    // R8: each flipped address bit defeats a match
    for (int b = 0; b < AW; b++)
      wr(A_ADDR ^ (AW'(1) << b), rep(8'hAA), 1'b1, 1'b0, "R8 address mismatch");

    // R10: power-on init clears the flag
    enablePrefix();
    winEnd(1'b1, "R1 armed for init test");
    @(negedge clk); porInit = 1'b1;
    @(negedge clk); porInit = 1'b0;
    chk("R10 init clears", protectOn, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule